// File: doc/BRIEF.md
# Stack Processor Instruction Sequencer

This unit steers instruction flow for a 16-bit processor with separate data and return stacks. Each clock it takes one word from a synchronous code memory. The top bit of the word decides how the word is treated. When that bit is 0, the word is a subroutine call and the lower fifteen bits give the word address of the target. When that bit is 1, the word is a general instruction, and a two-bit class field splits general instructions into data operations, memory operations, unconditional jumps and jumps taken on zero.

Returns have no opcode of their own. A data or memory word with its return flag (bit 5) set ends the current subroutine in the same cycle that the data unit carries out the operation. In jump words, bit 5 belongs to the target field instead. The sequencer holds the program counter and a 16-entry return stack. A data operation may also move a value onto the return stack or take one off it; that operation then claims the stack, and any return flag on the same word is refused. A memory word takes two cycles. During that time the fetch address is held so that the code memory keeps returning the same word.

The data unit receives a 12-bit operation code, the top of the return stack, and strobes for each memory phase. In return it supplies the value on top of its data stack and a zero flag.

Top module: `stack_seq_top`

## Requirements
- R1: While rst_n is low at a clock edge, the unit clears its state: after the edge code_addr is 0, the return stack is empty, rs_top is 0, and rs_overflow, rs_underflow, mem_addr_phase, mem_data_phase and illegal_combo are all 0. The first word executed after reset is the one at address 0.
- R2: A data word (bits 15:13 = 100) that has bit 5 clear and bits 12:11 not equal to 01 or 10 sets the next fetch address to the current address + 1. Each such word takes one clock. While it executes, dp_valid is 1 and dp_op equals {bits 12:6, bits 4:0}.
- R3: A word with bit 15 = 0 is a call. It sets the next fetch address to bits 14:0 and pushes the current address + 1 onto the return stack.
- R4: A data word with bit 5 set pops the return stack and uses the popped value as the next fetch address, in the same cycle that dp_valid issues its operation.
- R5: A jump word (bits 15:13 = 110) goes to {current address bits 14:13, word bits 12:0}. Bit 5 is treated as part of the target and never causes a pop.
- R6: A zero-jump word (bits 15:13 = 111) goes to the same target as R5 when dp_zero is 1. Otherwise it goes to the current address + 1.
- R7: A memory word (bits 15:13 = 101) takes two clocks. In the first, mem_addr_phase and dp_valid are 1 and code_addr repeats the current address. In the second, mem_data_phase is 1, and the word's return flag (if set) is applied in this cycle.
- R8: A data word with bits 12:11 = 01 pushes dp_tos onto the return stack; with bits 12:11 = 10 it pops one entry to the data unit. If such a word also has bit 5 set, illegal_combo is 1 for that cycle, the return flag is ignored, and the next fetch address is the current address + 1.
- R9: When the return stack already holds 16 entries, a further push is dropped and the entries already stored stay unchanged. rs_overflow then stays 1 until reset.
- R10: A pop from an empty return stack yields address 0, and rs_underflow then stays 1 until reset.
- R11: rs_top shows the entry most recently pushed and not yet popped, or 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_addr | output | 15 | Word address given to the synchronous code memory |
| code_data | input | 16 | Word read from the code memory, one clock after its address |
| dp_tos | input | 16 | Top of the data stack, used by a push to the return stack |
| dp_zero | input | 1 | Zero flag from the data unit, used by zero-jumps |
| dp_op | output | 12 | Operation code for the data unit |
| dp_valid | output | 1 | dp_op is issued this cycle |
| mem_addr_phase | output | 1 | First (address) cycle of a memory word |
| mem_data_phase | output | 1 | Second (transfer) cycle of a memory word |
| rs_top | output | 16 | Top entry of the return stack |
| illegal_combo | output | 1 | A return flag collided with a return-stack data operation |
| rs_overflow | output | 1 | Sticky: a push was dropped because the stack was full |
| rs_underflow | output | 1 | Sticky: a pop was made on an empty stack |

## Verification
All internal state is visible on code_addr within one clock, because that output is the next-address decision for the word in flight. A wrong stack pointer or a lost entry therefore appears at the first return that reads it. Such faults are found by nesting calls until the stack is full and then unwinding, checking every address in the unwind. A fault in memory-phase handling shows up as a code_addr that moves one cycle early. A wrong priority between return flag and stack operation shows up as a jump back to the caller where the next sequential address was expected.

// File: rtl/stack_seq_pkg.sv
// Package: shared field layout and decode types for the stack sequencer.
// Assumes a 16-bit instruction word; field positions are fixed here.
package stack_seq_pkg;

    localparam int INSTR_W = 16;
    localparam int PC_W    = INSTR_W - 1;   // call target fills bits 14:0
    localparam int JMP_W   = 13;            // jump target field width
    localparam int OP_W    = 12;            // operation code to the data unit
    localparam int RET_BIT = 5;             // return flag position

    typedef enum logic [1:0] {
        CLS_DATA = 2'b00,
        CLS_MEM  = 2'b01,
        CLS_JMP  = 2'b10,
        CLS_JZ   = 2'b11
    } gen_class_t;

    typedef enum logic [1:0] {
        RSX_NONE  = 2'b00,
        RSX_PUSH  = 2'b01,
        RSX_POP   = 2'b10,
        RSX_SPARE = 2'b11
    } rs_xfer_t;

    typedef struct packed {
        logic              is_call;
        gen_class_t        cls;
        rs_xfer_t          xfer;
        logic              ret_flag;
        logic [PC_W-1:0]   call_tgt;
        logic [JMP_W-1:0]  jmp_field;
        logic [OP_W-1:0]   op;
    } decoded_t;

endpackage

// File: rtl/stack_seq_decode.sv
// Module: pure combinational field split of one instruction word.
// Assumes the layout in stack_seq_pkg; applies no qualification by state.
module stack_seq_decode
    import stack_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output decoded_t           dec
);

    // Split the word into its fields.
    always_comb begin
        dec.is_call   = ~word[INSTR_W-1];
        dec.cls       = gen_class_t'(word[INSTR_W-2:INSTR_W-3]);
        dec.xfer      = rs_xfer_t'(word[INSTR_W-4:INSTR_W-5]);
        dec.ret_flag  = word[RET_BIT];
        dec.call_tgt  = word[PC_W-1:0];
        dec.jmp_field = word[JMP_W-1:0];
        dec.op        = {word[JMP_W-1:RET_BIT+1], word[RET_BIT-1:0]};
    end

endmodule

// File: rtl/stack_seq_rstack.sv
// Module: return-address stack with bounded pointer and sticky error flags.
// Assumes at most one of push/pop per cycle; a full push or empty pop
// leaves the array untouched and only sets its flag.
module stack_seq_rstack #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top,
    output logic         ovf,
    output logic         unf
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] top_pos;
    logic             full;
    logic             empty;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign top_pos = count - CNT_W'(1);

    // Present the top entry, or zero when nothing is stored.
    always_comb begin
        top = empty ? '0 : slots[top_pos[IDX_W-1:0]];
    end

    // Store a pushed value into the next free slot.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            slots[count[IDX_W-1:0]] <= wdata;
        end
    end

    // Move the pointer and latch the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf <= 1'b1;
                else      count <= count + CNT_W'(1);
            end else if (pop) begin
                if (empty) unf <= 1'b1;
                else       count <= top_pos;
            end
        end
    end

    AST_SINGLE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R8
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R9
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf); // R10

endmodule

// File: rtl/stack_seq_nextpc.sv
// Module: next fetch address selection by fixed priority.
// Assumes the take_* inputs are already qualified and mutually exclusive.
module stack_seq_nextpc #(
    parameter int PC_W  = 15,
    parameter int JMP_W = 13
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             run,
    input  logic             hold,
    input  logic             take_call,
    input  logic [PC_W-1:0]  call_tgt,
    input  logic             take_ret,
    input  logic [PC_W-1:0]  ret_addr,
    input  logic             take_jump,
    input  logic [JMP_W-1:0] jmp_field,
    output logic [PC_W-1:0]  npc
);

    // Choose where the next word comes from.
    always_comb begin
        if (!run || hold)   npc = pc;
        else if (take_call) npc = call_tgt;
        else if (take_ret)  npc = ret_addr;
        else if (take_jump) npc = {pc[PC_W-1:JMP_W], jmp_field};
        else                npc = pc + PC_W'(1);
    end

endmodule

// File: rtl/stack_seq_top.sv
// Module: fetch, call/return and memory-phase sequencing for a
// dual-stack processor. Assumes a code memory with one cycle of read
// latency that returns the word for code_addr at the next clock edge.
module stack_seq_top
    import stack_seq_pkg::*;
#(
    parameter int RS_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    code_addr,
    input  logic [INSTR_W-1:0] code_data,
    input  logic [INSTR_W-1:0] dp_tos,
    input  logic               dp_zero,
    output logic [OP_W-1:0]    dp_op,
    output logic               dp_valid,
    output logic               mem_addr_phase,
    output logic               mem_data_phase,
    output logic [INSTR_W-1:0] rs_top,
    output logic               illegal_combo,
    output logic               rs_overflow,
    output logic               rs_underflow
);

    logic [PC_W-1:0]    pc;
    logic               word_live;
    logic               mem_second;
    decoded_t           dec;
    logic               gen_word;
    logic               is_data;
    logic               is_mem;
    logic               stall;
    logic               rs_claim;
    logic               ret_take;
    logic               jump_take;
    logic               push;
    logic               pop;
    logic [INSTR_W-1:0] push_val;
    logic [PC_W-1:0]    npc;

    stack_seq_decode u_dec (
        .word (code_data),
        .dec  (dec)
    );

    // Qualify the decoded word with pipeline state.
    always_comb begin
        gen_word  = word_live && !dec.is_call;
        is_data   = gen_word && (dec.cls == CLS_DATA);
        is_mem    = gen_word && (dec.cls == CLS_MEM);
        stall     = is_mem && !mem_second;
        rs_claim  = is_data && (dec.xfer == RSX_PUSH || dec.xfer == RSX_POP);
        ret_take  = (is_data || is_mem) && dec.ret_flag && !rs_claim && !stall;
        jump_take = gen_word && ((dec.cls == CLS_JMP) ||
                                 (dec.cls == CLS_JZ && dp_zero));
        push      = (word_live && dec.is_call) || (is_data && dec.xfer == RSX_PUSH);
        pop       = ret_take || (is_data && dec.xfer == RSX_POP);
        push_val  = dec.is_call ? {1'b0, pc + PC_W'(1)} : dp_tos;
    end

    stack_seq_rstack #(
        .DEPTH (RS_DEPTH),
        .W     (INSTR_W)
    ) u_rs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (push_val),
        .top   (rs_top),
        .ovf   (rs_overflow),
        .unf   (rs_underflow)
    );

    stack_seq_nextpc #(
        .PC_W  (PC_W),
        .JMP_W (JMP_W)
    ) u_npc (
        .pc        (pc),
        .run       (word_live),
        .hold      (stall),
        .take_call (word_live && dec.is_call),
        .call_tgt  (dec.call_tgt),
        .take_ret  (ret_take),
        .ret_addr  (rs_top[PC_W-1:0]),
        .take_jump (jump_take),
        .jmp_field (dec.jmp_field),
        .npc       (npc)
    );

    // Drive the data-unit and memory strobes.
    always_comb begin
        code_addr      = npc;
        dp_op          = dec.op;
        dp_valid       = (is_data || is_mem) && !mem_second;
        mem_addr_phase = stall;
        mem_data_phase = is_mem && mem_second;
        illegal_combo  = rs_claim && dec.ret_flag;
    end

    // Advance the program counter and memory phase each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            word_live  <= 1'b0;
            mem_second <= 1'b0;
        end else begin
            pc         <= npc;
            word_live  <= 1'b1;
            mem_second <= stall;
        end
    end

    AST_MEM_SECOND_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_phase |=> mem_data_phase); // R7
    AST_MEM_HOLD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr_phase |-> (code_addr == pc)); // R7
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (word_live && dec.is_call) |-> (code_addr == dec.call_tgt)); // R3
    AST_CLAIM_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_combo |-> (code_addr == pc + PC_W'(1))); // R8

endmodule

// File: tb/stack_seq_top_test.sv
`timescale 1ns/1ps
module stack_seq_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] code_addr;
    logic [15:0] code_data;
    logic [15:0] dp_tos = 16'h0;
    logic        dp_zero = 1'b0;
    logic [11:0] dp_op;
    logic        dp_valid;
    logic        mem_addr_phase;
    logic        mem_data_phase;
    logic [15:0] rs_top;
    logic        illegal_combo;
    logic        rs_overflow;
    logic        rs_underflow;

    logic [15:0] rom [256];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk) code_data <= rom[code_addr[7:0]];

    stack_seq_top uut (
        .clk(clk), .rst_n(rst_n), .code_addr(code_addr), .code_data(code_data),
        .dp_tos(dp_tos), .dp_zero(dp_zero), .dp_op(dp_op), .dp_valid(dp_valid),
        .mem_addr_phase(mem_addr_phase), .mem_data_phase(mem_data_phase),
        .rs_top(rs_top), .illegal_combo(illegal_combo),
        .rs_overflow(rs_overflow), .rs_underflow(rs_underflow)
    );

    function automatic logic [15:0] w_call(input int t);
        return {1'b0, 15'(t)};
    endfunction
    function automatic logic [15:0] w_data(input int op7, input int ret, input int lo);
        return 16'h8000 | 16'((op7 & 7'h7f) << 6) | 16'((ret & 1) << 5) | 16'(lo & 5'h1f);
    endfunction
    function automatic logic [15:0] w_mem(input int op7, input int ret);
        return 16'hA000 | 16'((op7 & 7'h7f) << 6) | 16'((ret & 1) << 5);
    endfunction
    function automatic logic [15:0] w_jmp(input int t);
        return 16'hC000 | 16'(t & 13'h1fff);
    endfunction
    function automatic logic [15:0] w_jz(input int t);
        return 16'hE000 | 16'(t & 13'h1fff);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = w_data(3, 0, 0);
    endtask

    // Reset, check the reset state, release and stop while word 0 executes.
    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 code_addr", 32'(code_addr), 0);
        chk("R1 flags", {28'd0, rs_overflow, rs_underflow, mem_addr_phase, illegal_combo}, 0);
        chk("R1 rs_top", 32'(rs_top), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_sequential();
        clear_rom();
        rom[1] = w_data(7'h15, 0, 5'h1A);
        start();
        chk("R2 next addr", 32'(code_addr), 1);
        chk("R2 dp_valid", 32'(dp_valid), 1);
        chk("R2 dp_op", 32'(dp_op), 32'h060);
        step();
        chk("R2 next addr", 32'(code_addr), 2);
        chk("R2 dp_op fields", 32'(dp_op), 32'h2BA);
        for (int k = 3; k < 6; k++) begin
            step();
            chk("R2 one per clock", 32'(code_addr), 32'(k));
        end
    endtask

    task automatic t_call_return();
        clear_rom();
        rom[0]    = w_call(16'h40);
        rom[16'h40] = w_data(3, 1, 0);
        rom[1]    = w_call(16'h50);
        rom[16'h50] = w_call(16'h60);
        rom[16'h60] = w_data(5, 1, 0);
        rom[16'h51] = w_data(3, 1, 0);
        start();
        chk("R3 call target", 32'(code_addr), 32'h40);
        step();
        chk("R11 top after call", 32'(rs_top), 1);
        chk("R4 return addr", 32'(code_addr), 1);
        chk("R4 op issued with return", {31'd0, dp_valid}, 1);
        chk("R4 dp_op", 32'(dp_op), 32'h060);
        step();
        chk("R3 nested call", 32'(code_addr), 32'h50);
        step();
        chk("R3 second level", 32'(code_addr), 32'h60);
        chk("R11 top", 32'(rs_top), 2);
        step();
        chk("R11 top inner", 32'(rs_top), 32'h51);
        chk("R4 inner return", 32'(code_addr), 32'h51);
        step();
        chk("R4 outer return", 32'(code_addr), 2);
        step();
        chk("R2 after unwind", 32'(code_addr), 3);
        chk("R10 no underflow", 32'(rs_underflow), 0);
    endtask

    task automatic t_jump();
        clear_rom();
        rom[0] = w_jmp(13'h025);
        start();
        chk("R5 jump target", 32'(code_addr), 32'h25);
        chk("R5 no issue", 32'(dp_valid), 0);
        step();
        chk("R5 continues", 32'(code_addr), 32'h26);
        step();
        chk("R5 bit5 not return", 32'(rs_underflow), 0);
    endtask

    task automatic t_zero_jump();
        clear_rom();
        rom[0] = w_jz(13'h030);
        dp_zero = 1'b0;
        start();
        chk("R6 not taken", 32'(code_addr), 1);
        dp_zero = 1'b1;
        start();
        chk("R6 taken", 32'(code_addr), 32'h30);
        dp_zero = 1'b0;
    endtask

    task automatic t_memory();
        clear_rom();
        rom[0] = w_mem(1, 0);
        start();
        chk("R7 addr phase", {30'd0, mem_addr_phase, mem_data_phase}, 2);
        chk("R7 fetch held", 32'(code_addr), 0);
        chk("R7 issued", 32'(dp_valid), 1);
        step();
        chk("R7 data phase", {30'd0, mem_addr_phase, mem_data_phase}, 1);
        chk("R7 advance", 32'(code_addr), 1);
        chk("R7 no reissue", 32'(dp_valid), 0);
        step();
        chk("R7 phases idle", {30'd0, mem_addr_phase, mem_data_phase}, 0);
        chk("R7 next", 32'(code_addr), 2);
        clear_rom();
        rom[0]      = w_call(16'h70);
        rom[16'h70] = w_mem(2, 1);
        start();
        step();
        chk("R7 return deferred", 32'(code_addr), 32'h70);
        step();
        chk("R7 return in data phase", 32'(code_addr), 1);
    endtask

    task automatic t_claim();
        clear_rom();
        rom[0]      = w_call(16'h10);
        rom[16'h10] = w_data(7'h20, 1, 0);
        rom[16'h11] = w_data(7'h40, 1, 0);
        rom[16'h12] = w_data(3, 1, 0);
        dp_tos = 16'h1234;
        start();
        step();
        chk("R8 illegal on push", 32'(illegal_combo), 1);
        chk("R8 return ignored", 32'(code_addr), 32'h11);
        step();
        chk("R8 pushed value", 32'(rs_top), 32'h1234);
        chk("R8 illegal on pop", 32'(illegal_combo), 1);
        chk("R8 return ignored pop", 32'(code_addr), 32'h12);
        step();
        chk("R8 popped", 32'(rs_top), 1);
        chk("R8 legal return", {31'd0, illegal_combo}, 0);
        chk("R4 return after claim", 32'(code_addr), 1);
    endtask

    task automatic t_overflow();
        clear_rom();
        rom[0] = w_call(16'h40);
        for (int j = 0; j < 16; j++) begin
            rom[16'h40 + 2*j]     = w_call(16'h40 + 2*(j+1));
            rom[16'h40 + 2*j + 1] = w_data(3, 1, 0);
        end
        rom[16'h60] = w_data(3, 1, 0);
        start();
        for (int n = 1; n <= 16; n++) step();
        chk("R9 full no flag", 32'(rs_overflow), 0);
        chk("R9 deepest call", 32'(code_addr), 32'h60);
        step();
        chk("R9 overflow flag", 32'(rs_overflow), 1);
        chk("R9 dropped push", 32'(code_addr), 32'h5D);
        for (int j = 14; j >= 1; j--) begin
            step();
            chk("R9 entry intact", 32'(code_addr), 32'(16'h41 + 2*(j-1)));
        end
        step();
        chk("R9 bottom entry", 32'(code_addr), 1);
        chk("R9 overflow sticky", 32'(rs_overflow), 1);
        chk("R10 no underflow", 32'(rs_underflow), 0);
    endtask

    task automatic t_underflow();
        clear_rom();
        rom[0] = w_data(3, 1, 0);
        start();
        chk("R10 empty pop addr", 32'(code_addr), 0);
        chk("R11 empty top", 32'(rs_top), 0);
        step();
        chk("R10 underflow flag", 32'(rs_underflow), 1);
        rom[0] = w_data(3, 0, 0);
        step();
        step();
        chk("R10 underflow sticky", 32'(rs_underflow), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R0 watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_sequential();
        t_call_return();
        t_jump();
        t_zero_jump();
        t_memory();
        t_claim();
        t_overflow();
        t_underflow();
        start();
        chk("R1 sticky cleared", {30'd0, rs_overflow, rs_underflow}, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule